// File: doc/BRIEF.md
# ATA Multiword DMA Host Sequencer

This block is the host end of a parallel ATA multiword DMA data phase. After a command has been issued elsewhere, software or a controller loads a transfer length and a direction. The sequencer then waits for the drive to raise its request line. It grants the bus by pulling the acknowledge low and produces one read or write strobe per 16-bit word. On reads, each word goes into a receive FIFO. On writes, each word is taken from a transmit FIFO. The setup, active and recovery phases of every strobe are counted in system clock cycles fixed by parameters.

A burst can stop in three ways. The drive can withdraw its request during a strobe. The host FIFO can fill (read) or drain (write). The word count can reach zero. In each case the strobe in flight is finished, no further strobe follows, and the acknowledge is released. Once the acknowledge is idle again, a request that is still high, or one raised later, starts a fresh burst from the grant step until the word count is used up. A register cycle running elsewhere on the cable blocks any grant. Chip selects are forced inactive for as long as the acknowledge is held.

Top module: `mdma_host_seq`

## Requirements
- R1: While reset is held and right after it, `ata_dmack_n`, `ata_dior_n` and `ata_diow_n` are 1, and `ata_dd_oe`, `cmd_done`, `rxf_push` and `txf_pop` are 0.
- R2: `ata_dmack_n` falls only after `ata_dmarq` has been sampled high, with a nonzero word count and the FIFO able to move a word (receive FIFO not full on reads, transmit FIFO not empty on writes). It falls one clock edge after the edge at which all of these conditions are first seen together.
- R3: No grant is made while `pio_busy` is 1. A pending transfer starts once `pio_busy` returns to 0.
- R4: While `ata_dmack_n` is 0, both bits of `ata_cs_n` are 1. While `ata_dmack_n` is 1, `ata_cs_n` equals `pio_cs_n`.
- R5: The first strobe of a burst falls SETUP_CYC cycles after `ata_dmack_n` falls. Each strobe stays low for ACT_CYC cycles. Consecutive strobes in one burst are separated by REC_CYC+SETUP_CYC high cycles.
- R6: On a read (`cmd_read`=1), `ata_dd_in` is sampled at the clock edge where `ata_dior_n` rises. It is presented on `rxf_data` with a one-cycle `rxf_push`, one push per strobe, in strobe order.
- R7: On a write, `ata_dd_out` holds the transmit FIFO head from the setup phase through the strobe and the recovery phase. `txf_pop` pulses once per `ata_diow_n` strobe. `ata_dd_oe` is 1 throughout a write grant and is 0 whenever `ata_dmack_n` is 1.
- R8: If `ata_dmarq` is seen low during a strobe or its recovery phase, that strobe completes, no further strobe follows, and `ata_dmack_n` returns to 1. A new burst starts only when `ata_dmarq` is high again, and it moves the remaining words.
- R9: At the end of each recovery phase the burst ends if the receive FIFO is full (read) or the transmit FIFO is empty (write). A request still held high then restarts the burst as soon as the FIFO condition clears.
- R10: Each strobe decrements the loaded word count. When it reaches zero the burst ends, `cmd_done` pulses for exactly one cycle, and no further grant is made even with `ata_dmarq` high.
- R11: `cmd_start` is ignored while the word count is nonzero or a grant is active. A start with `cmd_words`=0 is also ignored and produces no strobe and no `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Load a new transfer (one-cycle pulse) |
| cmd_read | input | 1 | Direction of the loaded transfer: 1 = device to host |
| cmd_words | input | CNT_W | Number of 16-bit words to move |
| cmd_done | output | 1 | One-cycle pulse when the word count reaches zero |
| pio_busy | input | 1 | A register cycle is in progress; grants are held off |
| pio_cs_n | input | 2 | Chip selects from the register-cycle logic |
| ata_dmarq | input | 1 | Device DMA request |
| ata_dmack_n | output | 1 | DMA acknowledge, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_cs_n | output | 2 | Chip selects to the cable, active low |
| ata_dd_in | input | DATA_W | Data bus as seen from the cable |
| ata_dd_out | output | DATA_W | Data the host drives on writes |
| ata_dd_oe | output | 1 | Output enable for `ata_dd_out` |
| rxf_push | output | 1 | Write enable to the receive FIFO |
| rxf_data | output | DATA_W | Word written to the receive FIFO |
| rxf_full | input | 1 | Receive FIFO cannot take more words |
| txf_pop | output | 1 | Read acknowledge to the transmit FIFO (show-ahead) |
| txf_data | input | DATA_W | Head word of the transmit FIFO |
| txf_empty | input | 1 | Transmit FIFO holds no word |

## Verification
The acknowledge reacts one clock edge after the request, start and FIFO conditions line up. The first strobe follows SETUP_CYC cycles later. A FIFO push or pop appears in the cycle right after the strobe rises, and the done pulse lands in that same cycle for the last word. Stop conditions take effect at the end of the recovery phase that follows the strobe. The bench drives every input two nanoseconds after a rising edge and samples every output on the falling edge. For the grant it checks that the acknowledge is still high at the first falling edge and low at the second. Strobe widths, gaps and data order are measured continuously by run-length counters against the parameter arithmetic. Stop behaviour is judged only after the acknowledge has stayed idle for several cycles.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SETUP   = 3'd1,
      ST_STROBE  = 3'd2,
      ST_RECOVER = 3'd3,
      ST_RELEASE = 3'd4
   } seq_state_t;
endpackage

// File: rtl/mdma_phase_timer.sv
module mdma_phase_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain_q <= '0;
      else if (load)           remain_q <= load_val;
      else if (remain_q != '0) remain_q <= remain_q - 1'b1;
   end

   assign expired = (remain_q == '0);

   // R5: once expired the timer stays expired until reloaded
   a_r5_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);
endmodule

// File: rtl/mdma_word_counter.sv
module mdma_word_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero,
   output logic             done
);
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= dec && (left_q == CNT_W'(1));
         if (load)                     left_q <= load_val;
         else if (dec && left_q != '0) left_q <= left_q - 1'b1;
      end
   end

   assign zero = (left_q == '0);

   // R10: done is a single-cycle pulse and coincides with an exhausted count
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> zero);
endmodule

// File: rtl/mdma_host_seq.sv
module mdma_host_seq
   import mdma_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 16,
   parameter int SETUP_CYC = 2,
   parameter int ACT_CYC   = 4,
   parameter int REC_CYC   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_read,
   input  logic [CNT_W-1:0]  cmd_words,
   output logic              cmd_done,
   input  logic              pio_busy,
   input  logic [1:0]        pio_cs_n,
   input  logic              ata_dmarq,
   output logic              ata_dmack_n,
   output logic              ata_dior_n,
   output logic              ata_diow_n,
   output logic [1:0]        ata_cs_n,
   input  logic [DATA_W-1:0] ata_dd_in,
   output logic [DATA_W-1:0] ata_dd_out,
   output logic              ata_dd_oe,
   output logic              rxf_push,
   output logic [DATA_W-1:0] rxf_data,
   input  logic              rxf_full,
   output logic              txf_pop,
   input  logic [DATA_W-1:0] txf_data,
   input  logic              txf_empty
);
   localparam int LONG_A  = (SETUP_CYC > ACT_CYC) ? SETUP_CYC : ACT_CYC;
   localparam int LONGEST = (LONG_A > REC_CYC) ? LONG_A : REC_CYC;
   localparam int TMR_W   = $clog2(LONGEST) + 1;

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("SETUP_CYC must be at least 1");
   end
   if (ACT_CYC < 1) begin : g_bad_act
      $error("ACT_CYC must be at least 1");
   end
   if (REC_CYC < 2) begin : g_bad_rec
      $error("REC_CYC must be at least 2 so FIFO flags settle before the next strobe");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end

   seq_state_t       st_q, st_d;
   logic             rd_q;
   logic             dev_stop_q;
   logic             tmr_load, tmr_exp;
   logic [TMR_W-1:0] tmr_val;
   logic             cnt_zero, accept_cmd, fifo_block, grant_ok;
   logic             strobe_end, granted, end_burst;

   assign accept_cmd = cmd_start && cnt_zero && (st_q == ST_IDLE) && (cmd_words != '0);
   assign fifo_block = rd_q ? rxf_full : txf_empty;
   assign grant_ok   = (st_q == ST_IDLE) && !cnt_zero && ata_dmarq && !pio_busy && !fifo_block;
   assign strobe_end = (st_q == ST_STROBE) && tmr_exp;
   assign end_burst  = cnt_zero || dev_stop_q || !ata_dmarq || fifo_block;
   assign granted    = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_RECOVER);

   mdma_phase_timer #(.W(TMR_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .expired (tmr_exp)
   );

   mdma_word_counter #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept_cmd),
      .load_val(cmd_words),
      .dec     (strobe_end),
      .zero    (cnt_zero),
      .done    (cmd_done)
   );

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_IDLE: if (grant_ok) begin
            st_d = ST_SETUP; tmr_load = 1'b1; tmr_val = TMR_W'(SETUP_CYC - 1);
         end
         ST_SETUP: if (tmr_exp) begin
            st_d = ST_STROBE; tmr_load = 1'b1; tmr_val = TMR_W'(ACT_CYC - 1);
         end
         ST_STROBE: if (tmr_exp) begin
            st_d = ST_RECOVER; tmr_load = 1'b1; tmr_val = TMR_W'(REC_CYC - 1);
         end
         ST_RECOVER: if (tmr_exp) begin
            if (end_burst) st_d = ST_RELEASE;
            else begin
               st_d = ST_SETUP; tmr_load = 1'b1; tmr_val = TMR_W'(SETUP_CYC - 1);
            end
         end
         ST_RELEASE: st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         rd_q       <= 1'b0;
         dev_stop_q <= 1'b0;
         ata_dd_out <= '0;
         rxf_push   <= 1'b0;
         rxf_data   <= '0;
         txf_pop    <= 1'b0;
      end else begin
         st_q     <= st_d;
         rxf_push <= strobe_end && rd_q;
         txf_pop  <= strobe_end && !rd_q;
         if (accept_cmd) rd_q <= cmd_read;
         if (st_q == ST_IDLE) dev_stop_q <= 1'b0;
         else if (((st_q == ST_STROBE) || (st_q == ST_RECOVER)) && !ata_dmarq)
            dev_stop_q <= 1'b1;
         if (strobe_end && rd_q) rxf_data <= ata_dd_in;
         if ((st_d == ST_SETUP) && (st_q != ST_SETUP) && !rd_q) ata_dd_out <= txf_data;
      end
   end

   assign ata_dmack_n = !granted;
   assign ata_dior_n  = !((st_q == ST_STROBE) && rd_q);
   assign ata_diow_n  = !((st_q == ST_STROBE) && !rd_q);
   assign ata_dd_oe   = granted && !rd_q;

   for (genvar gi = 0; gi < 2; gi++) begin : g_cs
      assign ata_cs_n[gi] = granted ? 1'b1 : pio_cs_n[gi];
   end

   // R2: a grant edge is always preceded by a sampled request
   a_r2_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ata_dmack_n) |-> $past(ata_dmarq));
   // R3: no grant while a register cycle is running
   a_r3_grant_not_in_pio: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ata_dmack_n) |-> !$past(pio_busy));
   // R4: chip selects inactive for the whole grant
   a_r4_cs_idle_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !ata_dmack_n |-> (ata_cs_n == 2'b11));
   // R5: strobes only inside a grant and never both at once
   a_r5_strobe_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_dior_n || !ata_diow_n) |-> (!ata_dmack_n && (ata_dior_n || ata_diow_n)));
   // R7: bus released whenever acknowledge is idle
   a_r7_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
      ata_dmack_n |-> !ata_dd_oe);
   // R6: each read push follows a read strobe rising
   a_r6_push_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_push |-> ($past(!ata_dior_n) && ata_dior_n));
endmodule

// File: tb/tb_mdma_host_seq.sv
`timescale 1ns/1ps
module tb_mdma_host_seq;
   localparam int SETUP = 2;
   localparam int ACT   = 3;
   localparam int REC   = 2;
   localparam int CW    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          cmd_start = 0, cmd_read = 0, cmd_done;
   logic [CW-1:0] cmd_words = '0;
   logic          pio_busy = 0;
   logic [1:0]    pio_cs_n = 2'b11;
   logic          ata_dmarq, ata_dmack_n, ata_dior_n, ata_diow_n, ata_dd_oe;
   logic [1:0]    ata_cs_n;
   logic [15:0]   ata_dd_in, ata_dd_out, rxf_data, txf_data;
   logic          rxf_push, rxf_full, txf_pop, txf_empty;

   int checks = 0, failures = 0;
   int falls = 0, dior_rises = 0, wr_idx = 0, rx_pushes = 0, rd_ptr = 0, done_cnt = 0;
   int t_err = 0, cs_err = 0, oe_err = 0, grant_err = 0, data_err = 0, wd_err = 0;
   int kill_at = 1000000, rx_cap = 16, rx_drained = 0, src_avail = 0;
   logic req_on = 0;

   assign ata_dmarq = req_on && (falls < kill_at);
   assign ata_dd_in = 16'hA500 + 16'(dior_rises);
   assign rxf_full  = (rx_pushes - rx_drained) >= rx_cap;
   assign txf_data  = 16'h5A00 + 16'(rd_ptr);
   assign txf_empty = (rd_ptr >= src_avail);

   mdma_host_seq #(.DATA_W(16), .CNT_W(CW), .SETUP_CYC(SETUP), .ACT_CYC(ACT), .REC_CYC(REC)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read), .cmd_words(cmd_words),
      .cmd_done(cmd_done), .pio_busy(pio_busy), .pio_cs_n(pio_cs_n), .ata_dmarq(ata_dmarq),
      .ata_dmack_n(ata_dmack_n), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_cs_n(ata_cs_n),
      .ata_dd_in(ata_dd_in), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .rxf_push(rxf_push),
      .rxf_data(rxf_data), .rxf_full(rxf_full), .txf_pop(txf_pop), .txf_data(txf_data),
      .txf_empty(txf_empty));

   // protocol monitor, samples on the falling edge
   logic prev_strobe = 0, prev_dior = 1, prev_diow = 1, prev_dmack = 1, prev_req = 0, prev_pio = 0;
   logic first_in_burst = 1;
   int lo_run = 0, hi_run = 0;
   always @(negedge clk) begin
      logic strobe;
      strobe = !ata_dior_n || !ata_diow_n;
      if (rst_n) begin
         if (prev_dmack && !ata_dmack_n) begin
            if (!prev_req) grant_err++;   // R2
            if (prev_pio)  grant_err++;   // R3
         end
         if (!ata_dmack_n && ata_cs_n != 2'b11) cs_err++;
         if (ata_dmack_n && ata_cs_n != pio_cs_n) cs_err++;
         if (ata_dmack_n && ata_dd_oe) oe_err++;
         if (!ata_diow_n && !ata_dd_oe) oe_err++;
         if (!ata_diow_n && ata_dd_out != 16'h5A00 + 16'(wr_idx)) wd_err++;
         if (rxf_push) begin
            if (rxf_data != 16'hA500 + 16'(rx_pushes)) data_err++;
            rx_pushes++;
         end
         if (txf_pop) rd_ptr++;
         if (cmd_done) done_cnt++;
         if (strobe && !prev_strobe) begin
            if (first_in_burst) begin if (hi_run != SETUP) t_err++; end
            else if (hi_run != REC + SETUP) t_err++;
            first_in_burst = 0;
            hi_run = 0;
            falls++;
         end
         if (!strobe && prev_strobe && lo_run != ACT) t_err++;
         if (ata_dior_n && !prev_dior) dior_rises++;
         if (ata_diow_n && !prev_diow) wr_idx++;
         lo_run = strobe ? lo_run + 1 : 0;
         if (ata_dmack_n) begin hi_run = 0; first_in_burst = 1; end
         else if (!strobe) hi_run++;
      end
      prev_strobe = strobe; prev_dior = ata_dior_n; prev_diow = ata_diow_n;
      prev_dmack = ata_dmack_n; prev_req = ata_dmarq; prev_pio = pio_busy;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic start_cmd(input bit rd, input int n);
      step();
      cmd_start = 1; cmd_read = rd; cmd_words = CW'(n);
      step();
      cmd_start = 0;
   endtask

   task automatic wait_done(input int target);
      while (done_cnt < target) step();
   endtask

   task automatic wait_quiet();
      int q = 0;
      while (q < 8) begin step(); q = ata_dmack_n ? q + 1 : 0; end
   endtask

   bit finished = 0;
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int p0, d0, f0, r0, w0;
      repeat (3) step();
      // R1 during reset
      chk(ata_dmack_n && ata_dior_n && ata_diow_n, "R1 strobes idle in reset", ata_dmack_n, 1);
      chk(!ata_dd_oe && !cmd_done && !rxf_push && !txf_pop, "R1 enables low in reset", ata_dd_oe, 0);
      rst_n = 1;
      step();
      chk(ata_dmack_n && ata_dior_n && ata_diow_n && !ata_dd_oe, "R1 idle after reset", ata_dmack_n, 1);

      // T1 read burst, grant latency
      rx_drained = rx_pushes; p0 = rx_pushes; d0 = done_cnt;
      start_cmd(1, 5);
      step();
      req_on = 1;
      @(negedge clk); chk(ata_dmack_n == 1, "R2 no grant before request edge", ata_dmack_n, 1);
      @(negedge clk); chk(ata_dmack_n == 0, "R2 grant one edge after request", ata_dmack_n, 0);
      wait_done(d0 + 1); wait_quiet();
      chk(rx_pushes - p0 == 5, "R6 read words", rx_pushes - p0, 5);
      chk(done_cnt - d0 == 1, "R10 one done pulse", done_cnt - d0, 1);
      f0 = falls;
      repeat (10) step();
      chk(falls == f0 && ata_dmack_n, "R10 no grant after count exhausted", falls - f0, 0);

      // T2 write burst
      w0 = wr_idx; r0 = rd_ptr; d0 = done_cnt;
      src_avail = rd_ptr + 6;
      start_cmd(0, 6);
      wait_done(d0 + 1); wait_quiet();
      chk(wr_idx - w0 == 6, "R7 write strobes", wr_idx - w0, 6);
      chk(rd_ptr - r0 == 6, "R7 fifo pops", rd_ptr - r0, 6);

      // T3 device stop on the third strobe
      rx_drained = rx_pushes; p0 = rx_pushes; d0 = done_cnt;
      kill_at = falls + 3;
      start_cmd(1, 8);
      wait_quiet();
      chk(rx_pushes - p0 == 3, "R8 device stop words", rx_pushes - p0, 3);
      f0 = falls;
      repeat (10) step();
      chk(falls == f0 && ata_dmack_n, "R8 no regrant without request", falls - f0, 0);
      kill_at = 1000000;
      wait_done(d0 + 1); wait_quiet();
      chk(rx_pushes - p0 == 8, "R8 resumed burst total", rx_pushes - p0, 8);

      // T4 host stop on receive FIFO full
      rx_drained = rx_pushes; p0 = rx_pushes; d0 = done_cnt; rx_cap = 4;
      start_cmd(1, 7);
      wait_quiet();
      chk(rx_pushes - p0 == 4, "R9 stop on full", rx_pushes - p0, 4);
      chk(ata_dmarq && ata_dmack_n, "R9 request held while released", ata_dmack_n, 1);
      rx_drained = rx_pushes;
      wait_done(d0 + 1); wait_quiet();
      chk(rx_pushes - p0 == 7, "R9 regrant on held request", rx_pushes - p0, 7);
      rx_cap = 16; rx_drained = rx_pushes;

      // T5 host stop on transmit FIFO empty
      r0 = rd_ptr; d0 = done_cnt;
      src_avail = rd_ptr + 2;
      start_cmd(0, 6);
      wait_quiet();
      chk(rd_ptr - r0 == 2, "R9 stop on empty", rd_ptr - r0, 2);
      src_avail = src_avail + 4;
      wait_done(d0 + 1); wait_quiet();
      chk(rd_ptr - r0 == 6, "R9 write resumed total", rd_ptr - r0, 6);

      // T6 register cycle blocks grant
      rx_drained = rx_pushes; p0 = rx_pushes; d0 = done_cnt; f0 = falls;
      pio_busy = 1; pio_cs_n = 2'b10;
      start_cmd(1, 2);
      repeat (12) step();
      chk(falls == f0 && ata_dmack_n, "R3 no grant during register cycle", falls - f0, 0);
      chk(ata_cs_n == 2'b10, "R4 chip selects pass through when idle", ata_cs_n, 2);
      pio_busy = 0; pio_cs_n = 2'b11;
      wait_done(d0 + 1); wait_quiet();
      chk(rx_pushes - p0 == 2, "R3 transfer after register cycle", rx_pushes - p0, 2);

      // T7 start while busy is ignored
      rx_drained = rx_pushes; p0 = rx_pushes; r0 = rd_ptr; d0 = done_cnt;
      start_cmd(1, 4);
      repeat (3) step();
      start_cmd(0, 9);
      wait_done(d0 + 1); wait_quiet();
      chk(rx_pushes - p0 == 4, "R11 length kept", rx_pushes - p0, 4);
      chk(rd_ptr - r0 == 0, "R11 direction kept", rd_ptr - r0, 0);
      chk(done_cnt - d0 == 1, "R11 single done", done_cnt - d0, 1);

      // T8 zero-length start ignored, then single word write
      f0 = falls; d0 = done_cnt;
      start_cmd(1, 0);
      repeat (12) step();
      chk(falls == f0 && done_cnt == d0, "R11 zero length ignored", falls - f0, 0);
      w0 = wr_idx; src_avail = rd_ptr + 1;
      start_cmd(0, 1);
      wait_done(d0 + 1); wait_quiet();
      chk(wr_idx - w0 == 1, "R10 single word", wr_idx - w0, 1);

      // continuous monitor results
      chk(t_err == 0, "R5 strobe timing", t_err, 0);
      chk(cs_err == 0, "R4 chip selects", cs_err, 0);
      chk(oe_err == 0, "R7 output enable", oe_err, 0);
      chk(grant_err == 0, "R2 R3 grant conditions", grant_err, 0);
      chk(data_err == 0, "R6 read data order", data_err, 0);
      chk(wd_err == 0, "R7 write data", wd_err, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule